// File: doc/BRIEF.md
# Center-Aligned PWM Timer Channel

This block is a general-purpose timer that drives one pulse-width-modulated output. A prescaler divides the clock into count ticks. A counter steps on each tick, limited by a reload value. One compare channel turns the count into a PWM level and a sticky compare flag. The counter either runs edge-aligned, counting up or down and wrapping at the ends of its range, or center-aligned, sweeping up to the reload value and back down to zero. There are three center-aligned variants. They differ only in which sweep direction may raise the compare flag.

Software configures the block through plain write strobes, one for each value: prescaler, reload and compare. Reload and compare each have a preload switch. With preload off, a write takes effect in the next cycle. With preload on, the write lands in a shadow copy, which becomes active at the next update event, that is, at a wrap or a turnaround of the counter. This lets the period and duty be changed while the timer runs without a torn PWM cycle. No data streams through the block, so every pin is a plain control or status signal and none of them has valid/ready back-pressure.

Top module: `cpwm_timer`

## Requirements
- R1: While `run_i` is high, the count advances once every PSC+1 clock cycles, where PSC is the programmed prescaler value. After a counter clear, the first advance comes on the (PSC+1)-th cycle with `run_i` high. While `run_i` is low and no clear is requested, the count holds.
- R2: In edge mode (`align_i`=00) with `dir_down_i`=0, the count steps 0,1,...,ARR and then wraps to 0. `upd_o` is high for the one cycle in which the wrapped 0 is shown.
- R3: In edge mode with `dir_down_i`=1, the count steps down from 0 to ARR and then to 0, repeating. `upd_o` is high in each cycle that shows the count reloaded to ARR.
- R4: In center modes (`align_i`=01, 10, 11) with ARR of at least 1, the count runs 0 up to ARR and back down to 0, so one period is 2*ARR ticks. `dir_o` is 1 while the count is on its downward leg, including the return to 0. `upd_o` marks each tick that leaves ARR and each tick that leaves 0, except the first tick after a clear.
- R5: `pwm_o` is high exactly when the current count is below the active compare value. A compare value of 0 keeps the output low. A compare value above ARR keeps it high.
- R6: In edge mode, the compare flag is set on any tick at which the count arrives at the active compare value, whatever the count direction.
- R7: In center mode 01, the flag is set only by an arrival on a downward step. In mode 10 it is set only by an arrival on an upward step. In mode 11 it is set by an arrival in either direction.
- R8: `flag_o` stays set until a cycle with `flag_clr_i` high. If a set and a clear fall in the same cycle, the set wins. `irq_o` equals `flag_o` when `irq_en_i` is high and is 0 otherwise.
- R9: With `cmp_pre_i`=0, a compare write is active from the next cycle. With `cmp_pre_i`=1, the written value becomes active only at the next update event.
- R10: With `arr_pre_i`=0, a reload write limits the count from the next cycle. With `arr_pre_i`=1, the current period completes with the old limit and the new value applies from the next update event.
- R11: `cnt_clr_i` forces the count to 0, restarts the prescaler and sets the center-mode direction to upward, all in the next cycle. It does not raise an update event.
- R12: After reset, the count is 0, the direction is upward, `pwm_o`, `flag_o`, `irq_o` and `upd_o` are 0, the active compare value is 0 and the active reload value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter enable |
| irq_en_i | input | 1 | Routes the compare flag to `irq_o` |
| align_i | input | 2 | 00 edge, 01 center/down-flag, 10 center/up-flag, 11 center/both |
| dir_down_i | input | 1 | Edge mode count direction, 1 = down |
| psc_we_i | input | 1 | Prescaler write strobe |
| psc_i | input | PSC_W | Prescaler value (divide by value+1) |
| arr_we_i | input | 1 | Reload write strobe |
| arr_i | input | CNT_W | Reload value |
| arr_pre_i | input | 1 | Reload preload enable |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_i | input | CNT_W | Compare value |
| cmp_pre_i | input | 1 | Compare preload enable |
| cnt_clr_i | input | 1 | Clear count and prescaler |
| flag_clr_i | input | 1 | Clear the compare flag |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | Current count direction, 1 = down |
| upd_o | output | 1 | Update event seen on the last edge |
| pwm_o | output | 1 | PWM level |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the turnaround points in center mode. A design that treats the step away from ARR as upward would raise the flag in mode 10 when it should not, and would miss it in mode 01. It also covers duty extremes of 0 and ARR+1, where an off-by-one comparison would leak a one-tick pulse. Prescaler settings above zero are included, because a miscounted divider shifts every tick by a cycle. Shadow writes are issued mid-period: a design that loads them immediately would change the duty or the period before the wrap. A design that never loads them would keep the old limit forever.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE  = 2'b00,
    ALIGN_CDOWN = 2'b01,
    ALIGN_CUP   = 2'b10,
    ALIGN_CBOTH = 2'b11
  } align_e;
endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] pcnt_q;

  // Divide ratio register: written directly, used from the next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (psc_we) div_q <= psc_val;
  end

  assign tick = run && !clr && (pcnt_q >= div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt_q <= '0;
    else if (clr) pcnt_q <= '0;
    else if (run) pcnt_q <= (pcnt_q >= div_q) ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] val,
  input  logic         pre_en,
  input  logic         upd,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow_q <= RST_VAL;
    else if (we) shadow_q <= val;
  end

  // A direct write beats a pending shadow transfer in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              active <= RST_VAL;
    else if (we && !pre_en)  active <= val;
    else if (upd && pre_en)  active <= shadow_q;
  end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  align_e           align,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step_down,
  output logic             dir_q,
  output logic             upd_evt,
  output logic             upd_q
);
  logic dir_nxt;
  logic wrap;

  always_comb begin
    cnt_nxt   = cnt_q;
    dir_nxt   = dir_q;
    wrap      = 1'b0;
    step_down = 1'b0;
    if (align == ALIGN_EDGE) begin
      dir_nxt = dir_down;
      if (dir_down) begin
        step_down = 1'b1;
        if (cnt_q == '0) begin
          cnt_nxt = limit;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end else begin
        if (cnt_q >= limit) begin
          cnt_nxt = '0;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
    end else begin
      if (!dir_q) begin
        if (cnt_q >= limit) begin
          // top turnaround: this step already counts as downward
          dir_nxt   = 1'b1;
          step_down = 1'b1;
          wrap      = 1'b1;
          cnt_nxt   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          // bottom turnaround: this step counts as upward
          dir_nxt = 1'b0;
          wrap    = 1'b1;
          cnt_nxt = (limit == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          step_down = 1'b1;
          cnt_nxt   = cnt_q - 1'b1;
        end
      end
    end
  end

  assign upd_evt = tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_evt;
      if (tick) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
    end
  end
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  align_e           align,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             step_down,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             pwm,
  output logic             flag_q,
  output logic             irq
);
  logic dir_ok;
  logic hit;

  always_comb begin
    unique case (align)
      ALIGN_CDOWN: dir_ok = step_down;
      ALIGN_CUP:   dir_ok = !step_down;
      default:     dir_ok = 1'b1;
    endcase
  end

  assign hit = tick && (cnt_nxt == cmp_act) && dir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign pwm = (cnt_q < cmp_act);
  assign irq = flag_q && irq_en;
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic [1:0]       align_i,
  input  logic             dir_down_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             arr_pre_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cmp_pre_i,
  input  logic             cnt_clr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             upd_o,
  output logic             pwm_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;

  align_e           mode;
  logic             tick;
  logic             upd_evt;
  logic             step_down;
  logic             dir_q;
  logic [CNT_W-1:0] arr_act;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cnt_nxt;

  assign mode = align_e'(align_i);

  cpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_i), .clr(cnt_clr_i),
    .psc_we(psc_we_i), .psc_val(psc_i), .tick(tick)
  );

  cpwm_shadow #(.W(CNT_W), .RST_VAL(ARR_RST)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we_i), .val(arr_i),
    .pre_en(arr_pre_i), .upd(upd_evt), .active(arr_act)
  );

  cpwm_shadow #(.W(CNT_W), .RST_VAL('0)) u_cmp (
    .clk(clk), .rst_n(rst_n), .we(cmp_we_i), .val(cmp_i),
    .pre_en(cmp_pre_i), .upd(upd_evt), .active(cmp_act)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr_i),
    .align(mode), .dir_down(dir_down_i), .limit(arr_act),
    .cnt_q(cnt_o), .cnt_nxt(cnt_nxt), .step_down(step_down),
    .dir_q(dir_q), .upd_evt(upd_evt), .upd_q(upd_o)
  );

  cpwm_compare #(.CNT_W(CNT_W)) u_cmpu (
    .clk(clk), .rst_n(rst_n), .tick(tick), .align(mode),
    .cnt_q(cnt_o), .cnt_nxt(cnt_nxt), .step_down(step_down),
    .cmp_act(cmp_act), .flag_clr(flag_clr_i), .irq_en(irq_en_i),
    .pwm(pwm_o), .flag_q(flag_o), .irq(irq_o)
  );

  assign dir_o = (mode == ALIGN_EDGE) ? dir_down_i : dir_q;
endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             irq_en_i,
  input logic [1:0]       align_i,
  input logic             dir_down_i,
  input logic             cnt_clr_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             upd_o,
  input logic             flag_o,
  input logic             irq_o
);
  assert_hold_without_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_clr_i) |=> $stable(cnt_o));

  assert_edge_up_update_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (align_i == ALIGN_EDGE && !dir_down_i && !cnt_clr_i) |=> (upd_o |-> cnt_o == '0));

  assert_down_only_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && $past(align_i) == ALIGN_CDOWN && align_i == ALIGN_CDOWN) |-> dir_o);

  assert_up_only_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && $past(align_i) == ALIGN_CUP && align_i == ALIGN_CUP) |-> !dir_o);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_o == '0 && !upd_o));
endmodule

bind cpwm_timer cpwm_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/cpwm_timer_tb.sv
module cpwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_i = 1'b0, irq_en_i = 1'b0, dir_down_i = 1'b0;
  logic [1:0]    align_i = 2'b00;
  logic          psc_we_i = 1'b0, arr_we_i = 1'b0, arr_pre_i = 1'b0;
  logic          cmp_we_i = 1'b0, cmp_pre_i = 1'b0;
  logic          cnt_clr_i = 1'b0, flag_clr_i = 1'b0;
  logic [PW-1:0] psc_i = '0;
  logic [CW-1:0] arr_i = '0, cmp_i = '0;
  logic [CW-1:0] cnt_o;
  logic          dir_o, upd_o, pwm_o, flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_timer #(.CNT_W(CW), .PSC_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .irq_en_i(irq_en_i),
    .align_i(align_i), .dir_down_i(dir_down_i), .psc_we_i(psc_we_i),
    .psc_i(psc_i), .arr_we_i(arr_we_i), .arr_i(arr_i), .arr_pre_i(arr_pre_i),
    .cmp_we_i(cmp_we_i), .cmp_i(cmp_i), .cmp_pre_i(cmp_pre_i),
    .cnt_clr_i(cnt_clr_i), .flag_clr_i(flag_clr_i), .cnt_o(cnt_o),
    .dir_o(dir_o), .upd_o(upd_o), .pwm_o(pwm_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // sel: 0 edge up, 1 edge down, 2..4 center with align 01/10/11
  task automatic start(int sel, int a, int c, int p, bit fclr);
    run_i = 1'b0;
    align_i = (sel < 2) ? 2'b00 : 2'(sel - 1);
    dir_down_i = (sel == 1);
    arr_we_i = 1'b1; arr_i = CW'(a); arr_pre_i = 1'b0;
    cmp_we_i = 1'b1; cmp_i = CW'(c); cmp_pre_i = 1'b0;
    psc_we_i = 1'b1; psc_i = PW'(p);
    cnt_clr_i = 1'b1; flag_clr_i = 1'b1;
    step();
    arr_we_i = 1'b0; cmp_we_i = 1'b0; psc_we_i = 1'b0;
    cnt_clr_i = 1'b0; flag_clr_i = fclr;
    run_i = 1'b1;
  endtask

  task automatic wait_cnt(int v);
    for (int i = 0; i < 300; i++) begin
      if (int'(cnt_o) == v) return;
      step();
    end
    chk("wait_cnt timeout", int'(cnt_o), v);
  endtask

  function automatic int exp_cnt(int sel, int a, int n);
    int p;
    if (sel == 0) return n % (a + 1);
    if (sel == 1) return (a + 1 - (n % (a + 1))) % (a + 1);
    p = n % (2 * a);
    return (p <= a) ? p : 2 * a - p;
  endfunction

  function automatic bit exp_down(int sel, int a, int n);
    int p;
    if (sel < 2) return sel == 1;
    p = n % (2 * a);
    return (n > 0) && (p == 0 || p > a);
  endfunction

  function automatic bit exp_upd(int sel, int a, int n);
    int q;
    if (n < 1) return 1'b0;
    if (sel == 0) return (n % (a + 1)) == 0;
    if (sel == 1) return ((n - 1) % (a + 1)) == 0;
    q = (n - 1) % (2 * a);
    return (q == a) || (q == 0 && n > 1);
  endfunction

  task automatic sweep(int sel, int a, int c, int p);
    int e_max;
    int n;
    bit tk;
    bit dn;
    bit ok;
    int ec;
    start(sel, a, c, p, 1'b1);
    e_max = (p + 1) * 2 * ((sel < 2) ? a + 1 : 2 * a) + 1;
    for (int e = 1; e <= e_max; e++) begin
      step();
      n  = e / (p + 1);
      tk = (e % (p + 1)) == 0;
      ec = exp_cnt(sel, a, n);
      dn = exp_down(sel, a, n);
      if (sel == 0)      chk("R2 edge up count", int'(cnt_o), ec);
      else if (sel == 1) chk("R3 edge down count", int'(cnt_o), ec);
      else               chk("R4 center count", int'(cnt_o), ec);
      if (p > 0) chk("R1 prescaled count", int'(cnt_o), ec);
      chk("R5 pwm level", int'(pwm_o), int'(ec < c));
      if (sel >= 2) chk("R4 direction", int'(dir_o), int'(dn));
      chk("R4 update pulse", int'(upd_o), int'(tk && exp_upd(sel, a, n)));
      case (sel)
        2: ok = dn;
        3: ok = !dn;
        default: ok = 1'b1;
      endcase
      if (sel < 2) chk("R6 edge flag", int'(flag_o), int'(tk && n >= 1 && ec == c));
      else         chk("R7 gated flag", int'(flag_o), int'(tk && n >= 1 && ec == c && ok));
    end
  endtask

  int mx;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R12 reset count", int'(cnt_o), 0);
    chk("R12 reset pwm", int'(pwm_o), 0);
    chk("R12 reset flag", int'(flag_o), 0);
    chk("R12 reset irq", int'(irq_o), 0);
    chk("R12 reset upd", int'(upd_o), 0);
    chk("R12 reset dir", int'(dir_o), 0);

    // R1 hold with run low
    start(0, 5, 2, 0, 1'b1);
    repeat (3) step();
    run_i = 1'b0;
    step();
    mx = int'(cnt_o);
    repeat (4) step();
    chk("R1 hold when stopped", int'(cnt_o), mx);

    for (int sel = 0; sel < 5; sel++)
      for (int ai = 0; ai < 4; ai++) begin
        int a;
        a = (ai == 3) ? 5 : ai + 1;
        for (int c = 0; c <= a + 1; c++)
          for (int p = 0; p < 3; p++)
            sweep(sel, a, c, p);
      end

    // R9 compare preload
    start(0, 5, 2, 0, 1'b1);
    wait_cnt(1);
    cmp_we_i = 1'b1; cmp_i = 4'd4; cmp_pre_i = 1'b1;
    step();
    cmp_we_i = 1'b0;
    chk("R9 shadowed compare not yet active", int'(pwm_o), 0);
    wait_cnt(3);
    chk("R9 shadowed compare before update", int'(pwm_o), 0);
    wait_cnt(0);
    wait_cnt(3);
    chk("R9 shadowed compare after update", int'(pwm_o), 1);
    cmp_we_i = 1'b1; cmp_i = 4'd5; cmp_pre_i = 1'b0;
    step();
    cmp_we_i = 1'b0;
    chk("R9 direct compare write", int'(pwm_o), 1);

    // R10 reload preload then direct
    start(0, 5, 0, 0, 1'b1);
    wait_cnt(1);
    arr_we_i = 1'b1; arr_i = 4'd2; arr_pre_i = 1'b1;
    step();
    arr_we_i = 1'b0;
    mx = 0;
    for (int i = 0; i < 40 && !upd_o; i++) begin
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      step();
    end
    chk("R10 old limit kept until update", mx, 5);
    step();
    mx = 0;
    for (int i = 0; i < 40 && !upd_o; i++) begin
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      step();
    end
    chk("R10 new limit after update", mx, 2);
    arr_pre_i = 1'b0;
    wait_cnt(1);
    arr_we_i = 1'b1; arr_i = 4'd4;
    step();
    arr_we_i = 1'b0;
    mx = 0;
    for (int i = 0; i < 40 && !upd_o; i++) begin
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      step();
    end
    chk("R10 direct reload write", mx, 4);

    // R8 sticky flag and interrupt gating
    start(0, 5, 3, 0, 1'b0);
    irq_en_i = 1'b1;
    for (int i = 0; i < 40 && !flag_o; i++) step();
    chk("R8 flag set at compare", int'(cnt_o), 3);
    chk("R8 irq follows flag", int'(irq_o), 1);
    repeat (6) step();
    chk("R8 flag sticky", int'(flag_o), 1);
    irq_en_i = 1'b0;
    step();
    chk("R8 irq masked", int'(irq_o), 0);
    wait_cnt(4);
    flag_clr_i = 1'b1;
    step();
    flag_clr_i = 1'b0;
    chk("R8 flag cleared", int'(flag_o), 0);
    wait_cnt(2);
    flag_clr_i = 1'b1;
    step();
    flag_clr_i = 1'b0;
    chk("R8 set wins over clear", int'(flag_o), 1);

    // R11 counter clear
    start(0, 5, 2, 2, 1'b1);
    wait_cnt(3);
    cnt_clr_i = 1'b1;
    step();
    cnt_clr_i = 1'b0;
    chk("R11 clear forces zero", int'(cnt_o), 0);
    chk("R11 clear no update", int'(upd_o), 0);
    repeat (2) step();
    chk("R11 prescaler restarted hold", int'(cnt_o), 0);
    step();
    chk("R11 first tick after clear", int'(cnt_o), 1);
    start(4, 3, 9, 0, 1'b1);
    for (int i = 0; i < 40 && !dir_o; i++) step();
    cnt_clr_i = 1'b1;
    step();
    cnt_clr_i = 1'b0;
    chk("R11 center direction reset", int'(dir_o), 0);
    step();
    chk("R11 center counts up after clear", int'(cnt_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule